// File: doc/BRIEF.md
# Rule-Driven Port Director

This block sits after a packet classifier and converts each classified packet into a set of destination ports. The system has two external ports, A and C. Each has its own host-side port: B belongs to A and D belongs to C. Each external port is also paired with the opposite external port. For every packet, a descriptor arrives that names the ingress external port, says whether a rule matched, and gives the action attached to that rule. The block answers with a four-bit destination bitmap and a drop flag.

A software-written mode selects one of three behaviours:
- **Bypass:** matches go to the host, misses cross to the other external port.
- **Tap:** everything crosses, and matches are also copied to the host.
- **Filtering NIC:** matches go to the host, misses are dropped.

The mode is sampled when a descriptor is accepted, so a mode write never alters a decision already in flight. For each ingress port, the block counts packets sent across, packets sent to the host and packets dropped. These counts are read through a small synchronous read port.

Top module: `port_director`

## Requirements
- R1: Port and mode encodings. Ingress `in_src` is 0 for A and 1 for C. Bitmap bit0 is A, bit1 is B, bit2 is C and bit3 is D. Mode codes are 0 bypass, 1 tap and 2 filtering NIC. In bypass, a hit goes only to the ingress port's host (A→B, C→D) and a miss goes only to the other external port (A→C, C→A).
- R2: In tap mode, a miss goes only to the other external port, and a hit goes to both the other external port and the ingress port's host.
- R3: In filtering NIC mode, a hit goes only to the ingress port's host, and a miss produces an empty bitmap with the drop flag set.
- R4: When `in_act_drop` is 1 on a hit, the packet is dropped (empty bitmap, drop flag set) in every mode. On a miss, `in_act_drop` has no effect.
- R5: `out_drop` is 1 exactly when `out_dest` is all zero. An output never names its own ingress port or the other port's host.
- R6: A mode write (`cfg_we`) takes effect for descriptors accepted on later clock edges. A descriptor accepted on the same edge as the write, or earlier, uses the previous mode, even if its output is still stalled.
- R7: A mode write with code 3 is ignored and the previous mode stays in force.
- R8: Handshake timing:
  - `in_ready` equals `!out_valid || out_ready`.
  - A descriptor accepted at one edge is presented on the outputs after that edge, and exactly one output is given per accepted descriptor.
  - While `out_valid` is high and `out_ready` is low, the outputs hold steady.
- R9: Each ingress port has three counters, selected by `rd_addr` = {src, kind}:
  - kind 0 counts decisions whose bitmap includes the other external port.
  - kind 1 counts decisions whose bitmap includes the host port.
  - kind 2 counts drops.
  - kind 3 reads zero.
  - Counters update at acceptance. `rd_data` is valid one cycle after `rd_addr` is presented.
- R10: After reset, the mode is bypass, `out_valid` is 0, `in_ready` is 1 and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode write strobe |
| cfg_mode | input | 2 | Mode code to write |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted when high with in_valid |
| in_src | input | 1 | Ingress external port (0 A, 1 C) |
| in_hit | input | 1 | A classification rule matched |
| in_act_drop | input | 1 | Matched rule requests drop |
| out_valid | output | 1 | Decision valid |
| out_ready | input | 1 | Consumer accepts decision |
| out_src | output | 1 | Ingress port of the decision |
| out_dest | output | 4 | Destination bitmap {D,C,B,A} |
| out_drop | output | 1 | Packet is dropped |
| rd_addr | input | 3 | Counter select {src, kind[1:0]} |
| rd_data | output | CNT_W | Selected counter value |

## Verification
The hardest situation to reach is a mode write that races a descriptor in one of two ways: the write lands on the same edge as the acceptance, or it lands while the descriptor's decision is held in the output register by a stalled consumer. The bench reaches it in two ways. It drives a descriptor and a mode write in the same cycle. It also holds `out_ready` low, accepts a descriptor, rewrites the mode, and only then releases the stall. In both cases the decision must reflect the old mode, and the next descriptor must reflect the new one. Random backpressure over long streams then covers the remaining stall timings.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int DEST_W   = 4;
  localparam int NUM_SRC  = 2;
  localparam int NUM_KIND = 3;
  localparam int KIND_W   = 2;

  localparam logic [1:0] MODE_BYPASS = 2'd0;
  localparam logic [1:0] MODE_TAP    = 2'd1;
  localparam logic [1:0] MODE_FILTER = 2'd2;
  localparam logic [1:0] MODE_RSVD   = 2'd3;

  // Bit index of the host port and of the opposite external port per ingress
  function automatic int host_bit(input int src);
    return (src == 0) ? 1 : 3;
  endfunction

  function automatic int peer_bit(input int src);
    return (src == 0) ? 2 : 0;
  endfunction

  typedef struct packed {
    logic              src;
    logic [DEST_W-1:0] dest;
    logic              drop;
  } pd_verdict_t;
endpackage

// File: rtl/pd_mode_reg.sv
module pd_mode_reg
  import pd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [1:0] cfg_mode,
  output logic [1:0] mode
);
  always_ff @(posedge clk) begin
    if (rst) mode <= MODE_BYPASS;
    else if (cfg_we && cfg_mode != MODE_RSVD) mode <= cfg_mode;
  end

  // R7: reserved code never reaches the mode register
  a_r7_mode_legal: assert property (@(posedge clk) disable iff (rst)
    mode != MODE_RSVD);

  // R6: a legal write is visible one edge later
  a_r6_mode_follows: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_mode != MODE_RSVD) |=> (mode == $past(cfg_mode)));
endmodule

// File: rtl/pd_decide.sv
module pd_decide
  import pd_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic              src,
  input  logic              hit,
  input  logic              act_drop,
  output logic [DEST_W-1:0] dest,
  output logic              drop
);
  logic [DEST_W-1:0] host_m;
  logic [DEST_W-1:0] peer_m;

  always_comb begin
    host_m = '0;
    peer_m = '0;
    if (src) begin
      host_m[host_bit(1)] = 1'b1;
      peer_m[peer_bit(1)] = 1'b1;
    end else begin
      host_m[host_bit(0)] = 1'b1;
      peer_m[peer_bit(0)] = 1'b1;
    end
  end

  always_comb begin
    unique case (mode)
      MODE_TAP:    dest = hit ? (host_m | peer_m) : peer_m;
      MODE_FILTER: dest = hit ? host_m : '0;
      default:     dest = hit ? host_m : peer_m;
    endcase
    if (hit && act_drop) dest = '0;
  end

  // Drop decided from the rule and mode directly, not from the bitmap
  assign drop = (hit && act_drop) || (!hit && mode == MODE_FILTER);
endmodule

// File: rtl/pd_out_stage.sv
module pd_out_stage
  import pd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  pd_verdict_t in_verdict,
  output logic        out_valid,
  input  logic        out_ready,
  output pd_verdict_t out_verdict,
  output logic        accept
);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_verdict <= '0;
    end else begin
      if (accept) begin
        out_valid   <= 1'b1;
        out_verdict <= in_verdict;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R8: stalled output holds its content
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_verdict)));

  // R8: an accepted descriptor always yields a valid output next cycle
  a_r8_accept_presents: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);
endmodule

// File: rtl/pd_counters.sv
module pd_counters
  import pd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  pd_verdict_t       verdict,
  input  logic [KIND_W:0]   rd_addr,
  output logic [CNT_W-1:0]  rd_data
);
  logic [CNT_W-1:0] cnt [NUM_SRC][NUM_KIND];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int HB = host_bit(s);
    localparam int PB = peer_bit(s);
    for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
      logic bump;
      logic mine;
      assign mine = accept && (verdict.src == 1'(s));
      if (k == 0) begin : g_fwd
        assign bump = mine && verdict.dest[PB];
      end else if (k == 1) begin : g_host
        assign bump = mine && verdict.dest[HB];
      end else begin : g_drop
        assign bump = mine && verdict.drop;
      end

      always_ff @(posedge clk) begin
        if (rst) cnt[s][k] <= '0;
        else if (bump) cnt[s][k] <= cnt[s][k] + 1'b1;
      end

      // R9: counters move only on an accepted descriptor
      a_r9_count_on_accept: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(cnt[s][k]));
    end
  end

  logic             rd_src;
  logic [KIND_W-1:0] rd_kind;
  assign rd_src  = rd_addr[KIND_W];
  assign rd_kind = rd_addr[KIND_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      unique case (rd_kind)
        2'd0:    rd_data <= cnt[rd_src][0];
        2'd1:    rd_data <= cnt[rd_src][1];
        2'd2:    rd_data <= cnt[rd_src][2];
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/port_director.sv
module port_director
  import pd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_src,
  input  logic             in_hit,
  input  logic             in_act_drop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_src,
  output logic [3:0]       out_dest,
  output logic             out_drop,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  logic [1:0]  mode;
  pd_verdict_t nxt;
  pd_verdict_t cur;
  logic        accept;

  pd_mode_reg u_mode (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .mode(mode)
  );

  assign nxt.src = in_src;

  pd_decide u_decide (
    .mode(mode), .src(in_src), .hit(in_hit), .act_drop(in_act_drop),
    .dest(nxt.dest), .drop(nxt.drop)
  );

  pd_out_stage u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_verdict(nxt), .out_valid(out_valid), .out_ready(out_ready),
    .out_verdict(cur), .accept(accept)
  );

  pd_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .accept(accept), .verdict(nxt),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign out_src  = cur.src;
  assign out_dest = cur.dest;
  assign out_drop = cur.drop;

  // R5: drop flag agrees with an empty bitmap
  a_r5_drop_iff_empty: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_drop == (out_dest == 4'b0000)));

  // R5: never back to own ingress, never to the other port's host
  a_r5_no_self_no_foreign_host: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_src ? (!out_dest[2] && !out_dest[1])
                           : (!out_dest[0] && !out_dest[3])));
endmodule

// File: tb/test_port_director.sv
module test_port_director;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_src = 1'b0;
  logic in_hit = 1'b0;
  logic in_act_drop = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_src;
  logic [3:0] out_dest;
  logic out_drop;
  logic [2:0] rd_addr = 3'd0;
  logic [CNT_W-1:0] rd_data;

  port_director #(.CNT_W(CNT_W)) i_port_director (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
    .in_hit(in_hit), .in_act_drop(in_act_drop), .out_valid(out_valid),
    .out_ready(out_ready), .out_src(out_src), .out_dest(out_dest),
    .out_drop(out_drop), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model
  int m_mode = 0;
  int q_dest[$];
  int q_drop[$];
  int q_src[$];
  int m_cnt[2][4];
  int bp_sel = 0; // 0 always ready, 1 random, 2 held low

  function automatic int ref_dest(input int mode, input int src, input bit hit, input bit ad);
    int host, peer;
    host = (src == 0) ? 2 : 8;
    peer = (src == 0) ? 4 : 1;
    if (hit && ad) return 0;
    case (mode)
      1: return hit ? (host | peer) : peer;
      2: return hit ? host : 0;
      default: return hit ? host : peer;
    endcase
  endfunction

  function automatic string req_of(input int mode);
    case (mode)
      1: return "R2";
      2: return "R3";
      default: return "R1";
    endcase
  endfunction

  string q_req[$];

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(in_ready == (q_dest.size() == 0 || out_ready), "R8", "in_ready",
            in_ready, (q_dest.size() == 0 || out_ready));
      check(out_valid == (q_dest.size() != 0), "R8", "out_valid",
            out_valid, q_dest.size() != 0);
      if (out_valid && q_dest.size() != 0) begin
        check(out_dest == q_dest[0][3:0], q_req[0], "out_dest", out_dest, q_dest[0]);
        check(out_drop == q_drop[0][0], "R5", "out_drop", out_drop, q_drop[0]);
        check(out_src == q_src[0][0], "R8", "out_src", out_src, q_src[0]);
        if (out_ready) begin
          void'(q_dest.pop_front()); void'(q_drop.pop_front());
          void'(q_src.pop_front());  void'(q_req.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        int d, s;
        s = in_src;
        d = ref_dest(m_mode, s, in_hit, in_act_drop);
        q_dest.push_back(d);
        q_drop.push_back(d == 0);
        q_src.push_back(s);
        q_req.push_back((in_hit && in_act_drop) ? "R4" : req_of(m_mode));
        if (d & ((s == 0) ? 4 : 1)) m_cnt[s][0]++;
        if (d & ((s == 0) ? 2 : 8)) m_cnt[s][1]++;
        if (d == 0) m_cnt[s][2]++;
      end
      if (cfg_we && cfg_mode != 2'd3) m_mode = cfg_mode;
    end
  end

  always @(posedge clk) begin
    #1;
    case (bp_sel)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  task automatic drive(input bit s, input bit h, input bit ad);
    in_valid = 1'b1; in_src = s; in_hit = h; in_act_drop = ad;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic write_mode(input logic [1:0] m);
    cfg_we = 1'b1; cfg_mode = m;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic read_cnt(input int s, input int k, input string req);
    rd_addr = 3'((s << 2) | k);
    @(posedge clk); @(negedge clk);
    check(rd_data == ((k == 3) ? 0 : m_cnt[s][k]) % (1 << CNT_W), req,
          $sformatf("counter src%0d kind%0d", s, k), rd_data,
          (k == 3) ? 0 : m_cnt[s][k]);
  endtask

  task automatic finish_sim();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 3; k++) read_cnt(s, k, "R10");
    @(posedge clk); #2;

    // R1 R2 R3 R4: every combination in each mode, no backpressure
    for (int m = 0; m < 3; m++) begin
      write_mode(2'(m));
      for (int c = 0; c < 8; c++) drive(c[0], c[1], c[2]);
    end

    // R7: reserved code leaves filtering mode in place
    write_mode(2'd3);
    drive(1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0);

    // R6: write on same edge as acceptance uses the old mode
    in_valid = 1'b1; in_src = 1'b0; in_hit = 1'b0; in_act_drop = 1'b0;
    cfg_we = 1'b1; cfg_mode = 2'd1;
    @(negedge clk);
    @(posedge clk); #2;
    in_valid = 1'b0; cfg_we = 1'b0;
    drive(1'b0, 1'b0, 1'b0);

    // R6: write while decision is stalled in the output register
    bp_sel = 2;
    @(posedge clk); #2;
    drive(1'b1, 1'b1, 1'b0);
    write_mode(2'd0);
    repeat (3) @(posedge clk);
    bp_sel = 0;
    @(posedge clk); #2;
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b0);

    // R8: long random stream under random backpressure and mode changes
    bp_sel = 1;
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 17) == 0) write_mode(2'($urandom % 4));
      drive(1'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
    end
    bp_sel = 0;
    repeat (4) @(posedge clk);
    #2;

    // R9: counter readback, including the reserved kind
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 4; k++) read_cnt(s, k, "R9");

    finish_sim();
  end
endmodule